// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Tracker with Switchable Victim Policy

This block models the tag side of a four-block cache arranged as two sets of two ways. It stores no data. Each cycle in which the access strobe is high, it takes one block address and looks it up in the set chosen by the low address bit. One cycle later it reports whether the access hit. On a miss that had to displace a resident block, it also reports that block's full address. Two saturating counters give the running hit and miss totals.

The victim for a miss in a full set comes from a policy input that may change between any two accesses. The choices are least recently used, most recently used, or a pseudo-random bit. Each set is controlled by a small state machine with three states. SET_EMPTY holds no valid way. SET_ONE has way 0 valid. SET_FULL has both ways valid. The transitions are:

- fill-first: SET_EMPTY to SET_ONE, on any access.
- fill-second: SET_ONE to SET_FULL, on a miss.
- stay-on-hit: SET_ONE or SET_FULL to itself, on a hit.
- replace: SET_FULL to itself, on a miss.

A synchronous reset returns every set to SET_EMPTY. Each set also keeps a recency bit that names its most recently touched way.

Top module: `cache2w_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, every set becomes empty, the recency bits clear, the random generator is seeded with 16'hACE1, and `hit_o`, `evict_valid_o`, `evict_addr_o`, `hit_count_o` and `miss_count_o` all read zero on the following cycle.
- R2: Bit 0 of `acc_addr` selects the set, and bits 15:1 form the tag. Results are registered: they appear in the cycle after the strobe and stay unchanged, together with both counters, while `acc_valid` is low.
- R3: A miss in a set that is not full fills way 0 first and then way 1, with `evict_valid_o` low and `evict_addr_o` equal to zero. For the stream 0,1,2,3 every access misses with no eviction.
- R4: With `policy_sel` = 2'b00, or the spare code 2'b11, a miss in a full set evicts the way not touched most recently. For the stream 0,1,2,3,4 the fifth access evicts block 0.
- R5: With `policy_sel` = 2'b01, a miss in a full set evicts the most recently touched way. For the stream 0,2,4 the third access evicts block 2.
- R6: With `policy_sel` = 2'b10, the victim way equals bit 0 of a 16-bit shift register. Each access moves this register one place to the left and shifts in the XOR of its bits 15, 13, 12 and 10. The bit used by an access is the one present before that shift.
- R7: A hit never reports an eviction. A hit makes the hit way the most recently touched one, and so does a fill.
- R8: `hit_count_o` and `miss_count_o` count hits and misses. Each is 16 bits wide and holds at 16'hFFFF instead of wrapping.
- R9: Changing `policy_sel` does not alter the cache contents. A block resident before the change still hits after it.
- R10: On an eviction, `evict_addr_o` is the full block address of the displaced block, that is {its tag, the set index}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 16 | Block address of the access |
| policy_sel | input | 2 | Victim policy: 00 LRU, 01 MRU, 10 random, 11 LRU |
| hit_o | output | 1 | Last access hit |
| evict_valid_o | output | 1 | Last access displaced a block |
| evict_addr_o | output | 16 | Address of the displaced block, zero if none |
| hit_count_o | output | 16 | Saturating hit total |
| miss_count_o | output | 16 | Saturating miss total |

## Verification
Two functions can coincide in one cycle. A policy change can arrive on the very access that must evict, and a counter can reach saturation on an access that also evicts. The bench provokes the first with directed switches between MRU and LRU on a full set, and with a random stream that redraws the policy for every access. It judges both against a reference model that applies the policy carried by that same access. Saturation is provoked by a long run of hits on one block, after which the hit total must rest at 16'hFFFF while the miss total stays exact.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [1:0] {
        POL_LRU  = 2'b00,
        POL_MRU  = 2'b01,
        POL_RAND = 2'b10,
        POL_ALT  = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        SET_EMPTY = 2'b00,
        SET_ONE   = 2'b01,
        SET_FULL  = 2'b10
    } set_state_e;

endpackage

// File: rtl/c2w_lfsr.sv
module c2w_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic rnd_bit
);

    logic [W-1:0] q;
    logic         fb;

    always_comb begin
        fb      = ^(q & TAPS);
        rnd_bit = q[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEED;
        end else if (step) begin
            q <= {q[W-2:0], fb};
        end
    end

    // generator must never lock up in the all-zero state (R6)
    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (rst)
        q != '0);

endmodule

// File: rtl/c2w_satcnt.sv
module c2w_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        count == TOP |=> count == TOP);

    p_single_step_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1));

endmodule

// File: rtl/c2w_set.sv
module c2w_set
    import cache2w_pkg::*;
#(
    parameter int TAG_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [TAG_W-1:0] tag_in,
    input  policy_e          policy,
    input  logic             rnd_bit,
    output logic             hit_o,
    output logic             evict_o,
    output logic [TAG_W-1:0] evict_tag_o
);

    localparam int WAYS = 2;

    set_state_e       state_q, state_d;
    logic [TAG_W-1:0] tag_q [WAYS];
    logic             mru_q, mru_d;
    logic             hit_w0, hit_w1, any_hit;
    logic             victim;
    logic             fill_en;
    logic             fill_way;

    // lookup and victim choice
    always_comb begin
        hit_w0  = (state_q != SET_EMPTY) && (tag_q[0] == tag_in);
        hit_w1  = (state_q == SET_FULL) && (tag_q[1] == tag_in);
        any_hit = hit_w0 | hit_w1;
        unique case (policy)
            POL_MRU:  victim = mru_q;
            POL_RAND: victim = rnd_bit;
            default:  victim = ~mru_q;
        endcase
    end

    // next state
    always_comb begin
        state_d  = state_q;
        mru_d    = mru_q;
        fill_en  = 1'b0;
        fill_way = 1'b0;
        if (req) begin
            unique case (state_q)
                SET_EMPTY: begin
                    state_d  = SET_ONE;
                    fill_en  = 1'b1;
                    fill_way = 1'b0;
                    mru_d    = 1'b0;
                end
                SET_ONE: begin
                    if (hit_w0) begin
                        mru_d = 1'b0;
                    end else begin
                        state_d  = SET_FULL;
                        fill_en  = 1'b1;
                        fill_way = 1'b1;
                        mru_d    = 1'b1;
                    end
                end
                SET_FULL: begin
                    if (any_hit) begin
                        mru_d = hit_w1;
                    end else begin
                        fill_en  = 1'b1;
                        fill_way = victim;
                        mru_d    = victim;
                    end
                end
                default: state_d = SET_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        hit_o       = req && any_hit;
        evict_o     = req && (state_q == SET_FULL) && !any_hit;
        evict_tag_o = tag_q[victim];
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SET_EMPTY;
            mru_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mru_q   <= mru_d;
        end
    end

    // tag storage, one register per way
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == w[0])) begin
                tag_q[w] <= tag_in;
            end
        end
    end

    // one block never sits in both ways (R7)
    p_ways_distinct_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_w0, hit_w1}));

    // a full set only leaves SET_FULL through reset (R3)
    p_full_stays_r3: assert property (@(posedge clk) disable iff (rst)
        state_q == SET_FULL |=> state_q == SET_FULL);

    // after any request the set holds at least one block (R3)
    p_req_fills_r3: assert property (@(posedge clk) disable iff (rst)
        req |=> state_q != SET_EMPTY);

endmodule

// File: rtl/cache2w_tracker.sv
module cache2w_tracker
    import cache2w_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_SETS = 2,
    parameter int CNT_W    = 16,
    parameter int RND_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        policy_sel,
    output logic              hit_o,
    output logic              evict_valid_o,
    output logic [ADDR_W-1:0] evict_addr_o,
    output logic [CNT_W-1:0]  hit_count_o,
    output logic [CNT_W-1:0]  miss_count_o
);

    localparam int IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]    acc_idx;
    logic [TAG_W-1:0]    acc_tag;
    policy_e             policy;
    logic                rnd_bit;
    logic [NUM_SETS-1:0] set_req, set_hit, set_evict;
    logic [TAG_W-1:0]    set_evtag [NUM_SETS];
    logic                hit_any, evict_any;
    logic [TAG_W-1:0]    evict_tag;

    always_comb begin
        acc_idx = acc_addr[IDX_W-1:0];
        acc_tag = acc_addr[ADDR_W-1:IDX_W];
        policy  = policy_e'(policy_sel);
    end

    c2w_lfsr #(.W(RND_W)) u_rng (
        .clk     (clk),
        .rst     (rst),
        .step    (acc_valid),
        .rnd_bit (rnd_bit)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_comb set_req[s] = acc_valid && (acc_idx == s[IDX_W-1:0]);

        c2w_set #(.TAG_W(TAG_W)) u_set (
            .clk         (clk),
            .rst         (rst),
            .req         (set_req[s]),
            .tag_in      (acc_tag),
            .policy      (policy),
            .rnd_bit     (rnd_bit),
            .hit_o       (set_hit[s]),
            .evict_o     (set_evict[s]),
            .evict_tag_o (set_evtag[s])
        );
    end

    always_comb begin
        hit_any   = |set_hit;
        evict_any = |set_evict;
        evict_tag = set_evtag[acc_idx];
    end

    // registered results
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o         <= 1'b0;
            evict_valid_o <= 1'b0;
            evict_addr_o  <= '0;
        end else if (acc_valid) begin
            hit_o         <= hit_any;
            evict_valid_o <= evict_any;
            evict_addr_o  <= evict_any ? {evict_tag, acc_idx} : '0;
        end
    end

    c2w_satcnt #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .inc   (acc_valid && hit_any),
        .count (hit_count_o)
    );

    c2w_satcnt #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst   (rst),
        .inc   (acc_valid && !hit_any),
        .count (miss_count_o)
    );

    p_hit_no_evict_r7: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> !evict_valid_o);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(hit_o) && $stable(evict_valid_o) && $stable(evict_addr_o)
                       && $stable(hit_count_o) && $stable(miss_count_o));

    p_noevict_zero_addr_r3: assert property (@(posedge clk) disable iff (rst)
        !evict_valid_o |-> evict_addr_o == '0);

endmodule

// File: tb/cache2w_tracker_test.sv
module cache2w_tracker_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  policy_sel = '0;
    logic        hit_o, evict_valid_o;
    logic [15:0] evict_addr_o, hit_count_o, miss_count_o;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [14:0] m_tag [2][2];
    int          m_st  [2];
    logic        m_mru [2];
    logic [15:0] m_lfsr;
    logic [15:0] m_hits, m_miss;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache2w_tracker uut (
        .clk           (clk),
        .rst           (rst),
        .acc_valid     (acc_valid),
        .acc_addr      (acc_addr),
        .policy_sel    (policy_sel),
        .hit_o         (hit_o),
        .evict_valid_o (evict_valid_o),
        .evict_addr_o  (evict_addr_o),
        .hit_count_o   (hit_count_o),
        .miss_count_o  (miss_count_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_st[s]  = 0;
            m_mru[s] = 1'b0;
        end
        m_lfsr = 16'hACE1;
        m_hits = '0;
        m_miss = '0;
    endtask

    task automatic model_step(input logic [15:0] a, input logic [1:0] p,
                              output logic eh, output logic ev, output logic [15:0] ea);
        int          s;
        logic [14:0] t;
        logic        rnd, v, h0, h1;
        s   = int'(a[0]);
        t   = a[15:1];
        rnd = m_lfsr[0];
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        eh = 1'b0; ev = 1'b0; ea = '0;
        h0 = (m_st[s] >= 1) && (m_tag[s][0] == t);
        h1 = (m_st[s] == 2) && (m_tag[s][1] == t);
        if (h0) begin
            eh = 1'b1; m_mru[s] = 1'b0;
        end else if (h1) begin
            eh = 1'b1; m_mru[s] = 1'b1;
        end else if (m_st[s] == 0) begin
            m_tag[s][0] = t; m_st[s] = 1; m_mru[s] = 1'b0;
        end else if (m_st[s] == 1) begin
            m_tag[s][1] = t; m_st[s] = 2; m_mru[s] = 1'b1;
        end else begin
            if (p == 2'b01)      v = m_mru[s];
            else if (p == 2'b10) v = rnd;
            else                 v = ~m_mru[s];
            ev = 1'b1;
            ea = {m_tag[s][v], a[0]};
            m_tag[s][v] = t;
            m_mru[s] = v;
        end
        if (eh && m_hits != 16'hFFFF)  m_hits = m_hits + 1'b1;
        if (!eh && m_miss != 16'hFFFF) m_miss = m_miss + 1'b1;
    endtask

    // one access; called and returns at a falling edge
    task automatic access(input logic [15:0] a, input logic [1:0] p,
                          input string req, input bit verify);
        logic eh, ev;
        logic [15:0] ea;
        model_step(a, p, eh, ev, ea);
        acc_valid  = 1'b1;
        acc_addr   = a;
        policy_sel = p;
        @(negedge clk);
        acc_valid = 1'b0;
        if (verify) begin
            chk(req, "hit", hit_o, eh);
            chk(req, "evict_valid", evict_valid_o, ev);
            chk(req, "evict_addr", evict_addr_o, ea);
        end
    endtask

    task automatic check_counts(input string req);
        chk(req, "hit_count", hit_count_o, m_hits);
        chk(req, "miss_count", miss_count_o, m_miss);
    endtask

    task automatic idle(input string req);
        logic h, e;
        logic [15:0] ea, hc, mc;
        h = hit_o; e = evict_valid_o; ea = evict_addr_o;
        hc = hit_count_o; mc = miss_count_o;
        acc_addr = 16'h00FF;
        policy_sel = 2'b10;
        @(negedge clk);
        chk(req, "idle hit", hit_o, h);
        chk(req, "idle evict", evict_valid_o, e);
        chk(req, "idle addr", evict_addr_o, ea);
        chk(req, "idle hitcnt", hit_count_o, hc);
        chk(req, "idle misscnt", miss_count_o, mc);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1", "hit", hit_o, 1'b0);
        chk("R1", "evict_valid", evict_valid_o, 1'b0);
        chk("R1", "evict_addr", evict_addr_o, 16'h0);
        check_counts("R1");

        // R3 / R4 / R10: stream 0,1,2,3,4 in LRU
        access(16'd0, 2'b00, "R3", 1);
        access(16'd1, 2'b00, "R3", 1);
        access(16'd2, 2'b00, "R3", 1);
        access(16'd3, 2'b00, "R3", 1);
        chk("R3", "fill no evict", evict_valid_o, 1'b0);
        access(16'd4, 2'b00, "R4", 1);
        chk("R4", "evicted block 0", evict_addr_o, 16'd0);
        chk("R10", "evict flag", evict_valid_o, 1'b1);
        access(16'd3, 2'b11, "R7", 1);
        chk("R7", "hit no evict", {hit_o, evict_valid_o}, 2'b10);
        check_counts("R8");
        idle("R2");

        // R5 MRU: 0,2,4 evicts 2; then R9 policy change keeps contents
        do_reset();
        access(16'd0, 2'b01, "R5", 1);
        access(16'd2, 2'b01, "R5", 1);
        access(16'd4, 2'b01, "R5", 1);
        chk("R5", "evicted block 2", evict_addr_o, 16'd2);
        access(16'd0, 2'b00, "R9", 1);
        chk("R9", "resident after switch", hit_o, 1'b1);
        access(16'd6, 2'b00, "R4", 1);
        chk("R10", "evicted block 4", evict_addr_o, 16'd4);
        access(16'd9, 2'b10, "R6", 1);
        access(16'd11, 2'b10, "R6", 1);
        access(16'd13, 2'b10, "R6", 1);
        access(16'd15, 2'b10, "R6", 1);
        check_counts("R8");

        // R1 reset empties a loaded cache
        do_reset();
        access(16'd0, 2'b00, "R1", 1);
        chk("R1", "miss after reset", hit_o, 1'b0);

        // constrained random mix, policy redrawn per access (R6, R9)
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [1:0]  p;
            a = 16'($urandom_range(0, 9));
            if ($urandom_range(0, 7) == 0) a = a | 16'h8000;
            p = 2'($urandom_range(0, 3));
            access(a, p, "R6", 1);
            if ($urandom_range(0, 9) == 0) idle("R2");
        end
        check_counts("R8");

        // R8 saturation of the hit counter
        do_reset();
        for (int i = 0; i < 66000; i++) begin
            access(16'd0, 2'b00, "R8", 0);
        end
        check_counts("R8");
        chk("R8", "hit saturated", hit_count_o, 16'hFFFF);
        access(16'd2, 2'b00, "R8", 1);
        chk("R8", "miss after saturation", miss_count_o, 16'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule